// File: doc/BRIEF.md
# Priority-Ordered Pin Crossbar Decoder

This block places a fixed, prioritized list of internal peripheral signals onto a 32-pin port built from two 16-pin banks. Configuration comes in as three groups of levels: one enable bit per signal, one skip bit per pin, and a global crossbar enable. The block scans the pins from the lowest index upward. Each pin that is not skipped is handed to the next enabled signal, taking the signals from highest priority to lowest.

For every pin, the block drives a registered output value, an output enable and a claimed flag. Each signal carries a fixed direction (output, input or bidirectional), and that direction decides how a claimed pin is driven. The input value of a claimed pin is sent back to the signal that owns it. Pins that are not claimed pass straight through to a general-purpose I/O register interface. A signal that gets no pin reads an idle 1. When more signals are enabled than there are free pins, the lowest-priority signals stay unplaced and an overflow flag is raised.

Top module: `xbar_crossbar`

## Requirements
- R1: While `xbar_en` is 0, including the reset state, `pin_oe`, `pin_out`, `pin_claimed` and `pin_overflow` are all 0, and every bit of `sig_in` reads 1.
- R2: When the crossbar is enabled and no signal is enabled, every pin copies `gpio_out` and `gpio_oe` onto `pin_out` and `pin_oe`, and no pin is claimed.
- R3: Signal index 0 has the highest priority. The k-th enabled signal, counted in ascending index order, occupies the k-th non-skipped pin, counted upward from pin 0 (bank 0 pin 0) to pin 31 (bank 1 pin 15).
- R4: A pin whose `pin_skip` bit is 1 is never claimed. It stays a GPIO pin, and the search moves on to the next non-skipped pin.
- R5: A claimed pin is driven only by its signal. The signal's direction is its index modulo 3: 0 is output (`pin_out` = `sig_out`, `pin_oe` = 1), 1 is input (`pin_out` = 0, `pin_oe` = 0) and 2 is bidirectional (`pin_out` = `sig_out`, `pin_oe` = `sig_oe`).
- R6: Pins left over once every enabled signal is placed behave as GPIO pins, exactly as in R2.
- R7: Enabling one more higher-priority signal shifts every lower-priority signal up by one pin, unless a skipped pin lies between them.
- R8: When more signals are enabled than there are non-skipped pins, the lowest-priority excess signals get no pin and `pin_overflow` is 1. All non-skipped pins are then claimed.
- R9: For an input or bidirectional signal that owns a pin, `sig_in` equals that pin's `pin_in`. `sig_in` reads 1 for an output-direction signal, a signal that is not enabled, and a signal that got no pin.
- R10: `gpio_in` equals `pin_in` on unclaimed pins and reads 0 on claimed pins.
- R11: A configuration change applied before clock edge k is captured at edge k. Pin outputs and claim flags show the new assignment after edge k+1, and hold their old value in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xbar_en | input | 1 | Global crossbar enable |
| sig_en | input | NUM_SIGS | Per-signal enable, bit 0 highest priority |
| pin_skip | input | NUM_PINS | Per-pin skip mask |
| sig_out | input | NUM_SIGS | Output value from each peripheral signal |
| sig_oe | input | NUM_SIGS | Drive enable of bidirectional signals |
| sig_in | output | NUM_SIGS | Pin value returned to each signal, idle 1 |
| gpio_out | input | NUM_PINS | GPIO output value per pin |
| gpio_oe | input | NUM_PINS | GPIO output enable per pin |
| gpio_in | output | NUM_PINS | Pin input seen by GPIO, 0 on claimed pins |
| pin_in | input | NUM_PINS | Pad input value |
| pin_out | output | NUM_PINS | Registered pad output value |
| pin_oe | output | NUM_PINS | Registered pad output enable |
| pin_claimed | output | NUM_PINS | Pin is owned by a peripheral signal |
| pin_overflow | output | 1 | Enabled signals exceed free pins |

## Verification
The assignment is tried with several configurations. A contiguous group of enabled signals with no skips shows the basic ascending fill. Scattered skips placed across the bank boundary show that skipped pins are stepped over rather than counted. Enabling one extra high-priority signal before and after a skipped pin separates the shift-by-one behaviour from the case where the skip absorbs the change. A configuration with all signals enabled and most pins skipped drives the overflow path. Alternating `pin_in`, `sig_out` and GPIO patterns tell the three direction types, the return path and the GPIO passthrough apart. A one-edge sample after a reconfiguration confirms the two-edge latency.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int XB_BANK_PINS = 16;
    localparam int XB_BANKS     = 2;
    localparam int XB_PINS      = XB_BANK_PINS * XB_BANKS;
    localparam int XB_SIGS      = 12;

    typedef enum logic [1:0] {
        DIR_OUT   = 2'd0,
        DIR_IN    = 2'd1,
        DIR_BIDIR = 2'd2
    } sig_dir_e;

    typedef struct packed {
        logic out;
        logic oe;
        logic claimed;
    } pin_drv_t;

    // fixed direction attribute of each entry in the priority list
    function automatic sig_dir_e sig_dir(input int idx);
        case (idx % 3)
            0:       return DIR_OUT;
            1:       return DIR_IN;
            default: return DIR_BIDIR;
        endcase
    endfunction

endpackage

// File: rtl/xbar_cfg_reg.sv
module xbar_cfg_reg #(
    parameter int NUM_PINS = xbar_pkg::XB_PINS,
    parameter int NUM_SIGS = xbar_pkg::XB_SIGS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_i,
    input  logic [NUM_SIGS-1:0] sig_en_i,
    input  logic [NUM_PINS-1:0] skip_i,
    output logic                en_q,
    output logic [NUM_SIGS-1:0] sig_en_q,
    output logic [NUM_PINS-1:0] skip_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            sig_en_q <= '0;
            skip_q   <= '0;
        end else begin
            en_q     <= en_i;
            sig_en_q <= sig_en_i;
            skip_q   <= skip_i;
        end
    end

endmodule

// File: rtl/xbar_rank.sv
module xbar_rank #(
    parameter int NUM_SIGS = xbar_pkg::XB_SIGS,
    parameter int CW       = 6
) (
    input  logic [NUM_SIGS-1:0] sig_en,
    output logic [CW-1:0]       rank [NUM_SIGS],
    output logic [CW-1:0]       total
);

    logic [CW-1:0] pre [NUM_SIGS+1];

    assign pre[0] = '0;

    // running count of enabled signals of higher priority
    for (genvar s = 0; s < NUM_SIGS; s++) begin : g_pre
        assign pre[s+1] = pre[s] + CW'(sig_en[s]);
        assign rank[s]  = pre[s];
    end

    assign total = pre[NUM_SIGS];

endmodule

// File: rtl/xbar_pin_map.sv
module xbar_pin_map #(
    parameter int NUM_PINS = xbar_pkg::XB_PINS,
    parameter int NUM_SIGS = xbar_pkg::XB_SIGS,
    parameter int CW       = 6,
    parameter int IW       = 4
) (
    input  logic                en,
    input  logic [NUM_PINS-1:0] skip,
    input  logic [NUM_SIGS-1:0] sig_en,
    input  logic [CW-1:0]       rank [NUM_SIGS],
    input  logic [CW-1:0]       total,
    output logic [NUM_PINS-1:0] hit,
    output logic [IW-1:0]       idx [NUM_PINS],
    output logic [CW-1:0]       free_total,
    output logic                overflow
);

    logic [CW-1:0] slot [NUM_PINS+1];

    assign slot[0] = '0;

    // slot number of each pin among the non-skipped pins
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_slot
        assign slot[p+1] = slot[p] + CW'(!skip[p]);
    end

    assign free_total = slot[NUM_PINS];
    assign overflow   = en && (total > free_total);

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            hit[p] = 1'b0;
            idx[p] = '0;
            for (int s = 0; s < NUM_SIGS; s++) begin
                if (en && !skip[p] && sig_en[s] && (rank[s] == slot[p])) begin
                    hit[p] = 1'b1;
                    idx[p] = IW'(s);
                end
            end
        end
    end

endmodule

// File: rtl/xbar_out_stage.sv
module xbar_out_stage
    import xbar_pkg::*;
#(
    parameter int NUM_PINS = XB_PINS,
    parameter int NUM_SIGS = XB_SIGS,
    parameter int IW       = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [NUM_PINS-1:0] hit,
    input  logic [IW-1:0]       idx [NUM_PINS],
    input  logic                overflow,
    input  logic [NUM_SIGS-1:0] sig_out,
    input  logic [NUM_SIGS-1:0] sig_oe,
    input  logic [NUM_PINS-1:0] gpio_out,
    input  logic [NUM_PINS-1:0] gpio_oe,
    output logic [NUM_PINS-1:0] out_q,
    output logic [NUM_PINS-1:0] oe_q,
    output logic [NUM_PINS-1:0] claimed_q,
    output logic [IW-1:0]       idx_q [NUM_PINS],
    output logic                ovf_q
);

    pin_drv_t drv [NUM_PINS];

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            drv[p] = '0;
            if (en) begin
                if (hit[p]) begin
                    drv[p].claimed = 1'b1;
                    case (sig_dir(int'(idx[p])))
                        DIR_OUT: begin
                            drv[p].out = sig_out[idx[p]];
                            drv[p].oe  = 1'b1;
                        end
                        DIR_BIDIR: begin
                            drv[p].out = sig_out[idx[p]];
                            drv[p].oe  = sig_oe[idx[p]];
                        end
                        default: begin
                            drv[p].out = 1'b0;
                            drv[p].oe  = 1'b0;
                        end
                    endcase
                end else begin
                    drv[p].out = gpio_out[p];
                    drv[p].oe  = gpio_oe[p];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q     <= '0;
            oe_q      <= '0;
            claimed_q <= '0;
            ovf_q     <= 1'b0;
            for (int p = 0; p < NUM_PINS; p++) idx_q[p] <= '0;
        end else begin
            ovf_q <= overflow;
            for (int p = 0; p < NUM_PINS; p++) begin
                out_q[p]     <= drv[p].out;
                oe_q[p]      <= drv[p].oe;
                claimed_q[p] <= drv[p].claimed;
                idx_q[p]     <= idx[p];
            end
        end
    end

    // R1
    disabled_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (oe_q == '0) && (claimed_q == '0) && !ovf_q);

endmodule

// File: rtl/xbar_crossbar.sv
module xbar_crossbar
    import xbar_pkg::*;
#(
    parameter int NUM_PINS = XB_PINS,
    parameter int NUM_SIGS = XB_SIGS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                xbar_en,
    input  logic [NUM_SIGS-1:0] sig_en,
    input  logic [NUM_PINS-1:0] pin_skip,
    input  logic [NUM_SIGS-1:0] sig_out,
    input  logic [NUM_SIGS-1:0] sig_oe,
    output logic [NUM_SIGS-1:0] sig_in,
    input  logic [NUM_PINS-1:0] gpio_out,
    input  logic [NUM_PINS-1:0] gpio_oe,
    output logic [NUM_PINS-1:0] gpio_in,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_claimed,
    output logic                pin_overflow
);

    localparam int CW = $clog2(NUM_PINS + NUM_SIGS + 1);
    localparam int IW = (NUM_SIGS > 1) ? $clog2(NUM_SIGS) : 1;

    logic                en_q;
    logic [NUM_SIGS-1:0] sig_en_q;
    logic [NUM_PINS-1:0] skip_q;
    logic [CW-1:0]       rank [NUM_SIGS];
    logic [CW-1:0]       total;
    logic [NUM_PINS-1:0] hit;
    logic [IW-1:0]       idx [NUM_PINS];
    logic [CW-1:0]       free_total;
    logic                overflow;
    logic [IW-1:0]       idx_q [NUM_PINS];

    xbar_cfg_reg #(.NUM_PINS(NUM_PINS), .NUM_SIGS(NUM_SIGS)) cfg_i (
        .clk      (clk),
        .rst      (rst),
        .en_i     (xbar_en),
        .sig_en_i (sig_en),
        .skip_i   (pin_skip),
        .en_q     (en_q),
        .sig_en_q (sig_en_q),
        .skip_q   (skip_q)
    );

    xbar_rank #(.NUM_SIGS(NUM_SIGS), .CW(CW)) rank_i (
        .sig_en (sig_en_q),
        .rank   (rank),
        .total  (total)
    );

    xbar_pin_map #(.NUM_PINS(NUM_PINS), .NUM_SIGS(NUM_SIGS), .CW(CW), .IW(IW)) map_i (
        .en         (en_q),
        .skip       (skip_q),
        .sig_en     (sig_en_q),
        .rank       (rank),
        .total      (total),
        .hit        (hit),
        .idx        (idx),
        .free_total (free_total),
        .overflow   (overflow)
    );

    xbar_out_stage #(.NUM_PINS(NUM_PINS), .NUM_SIGS(NUM_SIGS), .IW(IW)) out_i (
        .clk       (clk),
        .rst       (rst),
        .en        (en_q),
        .hit       (hit),
        .idx       (idx),
        .overflow  (overflow),
        .sig_out   (sig_out),
        .sig_oe    (sig_oe),
        .gpio_out  (gpio_out),
        .gpio_oe   (gpio_oe),
        .out_q     (pin_out),
        .oe_q      (pin_oe),
        .claimed_q (pin_claimed),
        .idx_q     (idx_q),
        .ovf_q     (pin_overflow)
    );

    // return path built from the registered pin map
    always_comb begin
        sig_in = '1;
        for (int s = 0; s < NUM_SIGS; s++) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (pin_claimed[p] && (idx_q[p] == IW'(s)) && (sig_dir(s) != DIR_OUT))
                    sig_in[s] = pin_in[p];
            end
        end
    end

    assign gpio_in = pin_in & ~pin_claimed;

    // R4
    no_skip_claim_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pin_claimed & $past(skip_q)) == '0));

    // R8
    overflow_full_chk: assert property (@(posedge clk) disable iff (rst)
        pin_overflow |-> ($countones(pin_claimed) == int'($past(free_total))));

    // R3
    claim_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(pin_claimed) <= int'($past(total))));

endmodule

// File: tb/xbar_crossbar_tb_top.sv
`timescale 1ns/1ps
module xbar_crossbar_tb_top;

    localparam int NP = 32;
    localparam int NS = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          xbar_en = 1'b0;
    logic [NS-1:0] sig_en = '0;
    logic [NP-1:0] pin_skip = '0;
    logic [NS-1:0] sig_out = '0;
    logic [NS-1:0] sig_oe = '0;
    logic [NS-1:0] sig_in;
    logic [NP-1:0] gpio_out = '0;
    logic [NP-1:0] gpio_oe = '0;
    logic [NP-1:0] gpio_in;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [NP-1:0] pin_claimed;
    logic          pin_overflow;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [NP-1:0] e_out, e_oe, e_cl, e_gin;
    logic [NS-1:0] e_sin;
    logic          e_ovf;

    always #2.5 clk = ~clk;

    xbar_crossbar #(.NUM_PINS(NP), .NUM_SIGS(NS)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .xbar_en      (xbar_en),
        .sig_en       (sig_en),
        .pin_skip     (pin_skip),
        .sig_out      (sig_out),
        .sig_oe       (sig_oe),
        .sig_in       (sig_in),
        .gpio_out     (gpio_out),
        .gpio_oe      (gpio_oe),
        .gpio_in      (gpio_in),
        .pin_in       (pin_in),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe),
        .pin_claimed  (pin_claimed),
        .pin_overflow (pin_overflow)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference placement from the requirements: walk pins upward, hand out enabled signals in index order
    task automatic model();
        int s = 0;
        e_out = '0; e_oe = '0; e_cl = '0; e_sin = '1; e_ovf = 1'b0;
        if (xbar_en) begin
            for (int p = 0; p < NP; p++) begin
                while (s < NS && !sig_en[s]) s++;
                if (pin_skip[p] || s >= NS) begin
                    e_out[p] = gpio_out[p];
                    e_oe[p]  = gpio_oe[p];
                end else begin
                    e_cl[p] = 1'b1;
                    case (s % 3)
                        0: begin e_out[p] = sig_out[s]; e_oe[p] = 1'b1; end
                        1: begin e_out[p] = 1'b0; e_oe[p] = 1'b0; e_sin[s] = pin_in[p]; end
                        default: begin e_out[p] = sig_out[s]; e_oe[p] = sig_oe[s]; e_sin[s] = pin_in[p]; end
                    endcase
                    s++;
                end
            end
            while (s < NS && !sig_en[s]) s++;
            e_ovf = (s < NS);
        end
        e_gin = pin_in & ~e_cl;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input string req);
        model();
        chk({req, " pin_out"},     64'(pin_out),      64'(e_out));
        chk({req, " pin_oe"},      64'(pin_oe),       64'(e_oe));
        chk({req, " pin_claimed"}, 64'(pin_claimed),  64'(e_cl));
        chk({req, " overflow"},    64'(pin_overflow), 64'(e_ovf));
        chk({req, " sig_in"},      64'(sig_in),       64'(e_sin));
        chk({req, " gpio_in"},     64'(gpio_in),      64'(e_gin));
    endtask

    task automatic t_reset();
        // R1: reset state
        chk("R1 reset oe",      64'(pin_oe), 64'(0));
        chk("R1 reset claimed", 64'(pin_claimed), 64'(0));
        chk("R1 reset sig_in",  64'(sig_in), 64'({NS{1'b1}}));
        @(negedge clk); rst = 1'b0;
        gpio_out = 32'hA5A5_5A5A; gpio_oe = '1; sig_en = '1; sig_out = '1; sig_oe = '1;
        settle();
        check_all("R1 disabled");
        chk("R1 disabled oe", 64'(pin_oe), 64'(0));
    endtask

    task automatic t_gpio_only();
        xbar_en = 1'b1; sig_en = '0; pin_skip = '0;
        gpio_out = 32'h1234_F0E1; gpio_oe = 32'hFF00_0F0F; pin_in = 32'hCAFE_0123;
        settle();
        check_all("R2");
        chk("R2 oe passthrough", 64'(pin_oe), 64'(32'hFF00_0F0F));
    endtask

    task automatic t_fill();
        sig_en = 12'h03F; pin_skip = '0;
        sig_out = 12'hAAA; sig_oe = 12'h0F0; pin_in = 32'h0000_0036;
        settle();
        check_all("R3 R5 R6");
        chk("R3 claimed low six", 64'(pin_claimed), 64'(32'h3F));
        check_all("R9 R10");
    endtask

    task automatic t_skip();
        sig_en = 12'hF0F; pin_skip = 32'h0001_800F ^ 32'h0000_0005;
        sig_out = 12'h5A3; sig_oe = 12'hFFF; pin_in = 32'h00F0_3C3C;
        settle();
        check_all("R4");
        pin_skip = 32'h00FF_FF00;
        settle();
        check_all("R4 bank cross");
    endtask

    task automatic t_shift();
        pin_skip = '0; sig_en = 12'h00C;
        settle();
        chk("R7 before", 64'(pin_claimed), 64'(32'h3));
        sig_en = 12'h00D;
        settle();
        chk("R7 shifted", 64'(pin_claimed), 64'(32'h7));
        check_all("R7");
        // skipped pin 1 absorbs the insertion of signal 0
        pin_skip = 32'h2; sig_en = 12'h00C;
        settle();
        model();
        chk("R7 skip before", 64'(pin_claimed), 64'(32'h5));
        pin_skip = 32'h0; sig_en = 12'h00D;
        settle();
        chk("R7 unskip after", 64'(pin_claimed), 64'(32'h7));
        check_all("R7 absorb");
    endtask

    task automatic t_overflow();
        sig_en = '1; pin_skip = 32'hFFFF_FFC0 | 32'h0000_0004;
        sig_out = 12'h3C5; sig_oe = 12'hA5A; pin_in = 32'h0000_002A;
        settle();
        check_all("R8");
        chk("R8 flag", 64'(pin_overflow), 64'(1));
        pin_skip = '0;
        settle();
        chk("R8 cleared", 64'(pin_overflow), 64'(0));
    endtask

    task automatic t_latency();
        sig_en = 12'h007; pin_skip = '0;
        settle();
        chk("R11 base", 64'(pin_claimed), 64'(32'h7));
        pin_skip = 32'h1;
        @(posedge clk); @(negedge clk);
        chk("R11 one edge", 64'(pin_claimed), 64'(32'h7));
        @(posedge clk); @(negedge clk);
        chk("R11 two edges", 64'(pin_claimed), 64'(32'hE));
        xbar_en = 1'b0;
        settle();
        check_all("R1 re-disabled");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        t_reset();
        t_gpio_only();
        t_fill();
        t_skip();
        t_shift();
        t_overflow();
        t_latency();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule